// File: doc/BRIEF.md
# Request Lane Deserializer

This block sits right behind the receive clock domain of a memory device's request interface. Requests arrive on two narrow lanes that are sampled once per bit-time. The row lane is three wires wide and the column lane is five wires wide. A frame lasts eight bit-times and begins on a cycle marked by a frame-start strobe. During the frame, both lanes are shifted into wide words in lockstep. At the end of the frame, the row word becomes a 24-bit row packet. The 40-bit column word is cut into a 23-bit column-operation packet and a 17-bit secondary packet.

The wires carry low-true levels, so the block inverts them before it assembles anything. Each packet holds a 5-bit device field, which is compared with the `dev_id` input. A valid strobe is raised only for a packet addressed to this device. A flag bit in the row packet decides whether the strobe is reported as an activate request or as a row-operation request. A flag bit in the column-operation packet decides whether the secondary packet is reported as a byte-mask packet or as an extended-operation packet. Executing the commands is left to downstream logic.

Top module: `reqdes_top`

## Requirements
- R1: The logic value taken from row wire j at bit-time t (t = 0 on the frame-start cycle) lands in `row_pkt[3*t+j]`. The complete packet appears, together with its strobe, in the cycle after the clock edge that samples bit-time 7, and the strobe lasts that one cycle only.
- R2: The logic value taken from column wire j at bit-time t lands in bit 5*t+j of a 40-bit word. `col_pkt` is bits 22..0 of that word and `sec_pkt` is bits 39..23. Both appear in the same cycle as the row packet.
- R3: All lane wires are low-true: a low wire level is read as logic 1 and a high level as logic 0.
- R4: The row strobes fire only when `row_pkt[4:0]` equals `dev_id`. When they match and `row_pkt[5]` is 1, `row_act_vld` pulses. When they match and `row_pkt[5]` is 0, `row_op_vld` pulses.
- R5: `col_vld` pulses only when `col_pkt[4:0]` equals `dev_id`. Exactly one of the secondary strobes accompanies it, and neither secondary strobe ever fires without it.
- R6: On a column match, `col_pkt[5]` = 1 raises `mask_vld` (byte-mask meaning) and `col_pkt[5]` = 0 raises `xop_vld` (extended-operation meaning).
- R7: `row_act_vld` and `row_op_vld` never pulse together.
- R8: A frame-start arriving in the middle of a frame restarts both lanes at bit-time 0. The bit-times already collected are dropped and produce no strobe.
- R9: Reset clears both frame counters and all strobes. After reset, lane activity without a frame-start produces no strobe, and a frame cut off by reset never completes.
- R10: Both lanes finish on the same cycle. A frame-start on the cycle right after bit-time 7 starts the next frame with no gap, giving one packet set every eight cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one bit-time per cycle |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Marks bit-time 0 of a frame |
| row_wire | input | 3 | Row request lane, low-true |
| col_wire | input | 5 | Column request lane, low-true |
| dev_id | input | 5 | Address this device answers to |
| row_act_vld | output | 1 | Matching row packet with activate flag set |
| row_op_vld | output | 1 | Matching row packet with activate flag clear |
| row_pkt | output | 24 | Assembled row packet |
| col_vld | output | 1 | Matching column-operation packet |
| mask_vld | output | 1 | Secondary packet carries a byte mask |
| xop_vld | output | 1 | Secondary packet carries an extended operation |
| col_pkt | output | 23 | Assembled column-operation packet |
| sec_pkt | output | 17 | Assembled secondary packet |

## Verification
The bench uses the default parameters: lanes of three and five wires, eight bit-times, a 5-bit device field, a 23-bit operation packet and low-true wires. With these values every bit position of both words can be reached directly from the wires. The vectors drive the device field through 0, 1, 3, 16, 30 and 31, with both flag values on both lanes. That covers hits and misses at both ends of the address range, all-ones and all-zeros wire levels, frame restarts, reset in mid-frame and frames sent back to back.

// File: rtl/reqdes_pkg.sv
package reqdes_pkg;

   typedef enum logic {
      FR_IDLE = 1'b0,
      FR_RUN  = 1'b1
   } frame_st_e;

   typedef struct packed {
      logic hit_set;
      logic hit_clr;
   } hit_t;

endpackage

// File: rtl/reqdes_lane.sv
module reqdes_lane
   import reqdes_pkg::*;
#(
   parameter int LANE_W   = 3,
   parameter int BEATS    = 8,
   parameter bit LOW_TRUE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      frame_start,
   input  logic [LANE_W-1:0]         lane_wire,
   output logic [LANE_W*BEATS-1:0]   word_q,
   output logic                      done_q
);

   localparam int WORD_W = LANE_W * BEATS;
   localparam int HOLD_W = LANE_W * (BEATS - 1);
   localparam int CNT_W  = (BEATS > 2) ? $clog2(BEATS) : 1;
   localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

   logic [LANE_W-1:0] bits;
   logic [HOLD_W-1:0] hold;
   logic [HOLD_W-1:0] hold_nxt;
   logic [CNT_W-1:0]  beat;
   logic [CNT_W-1:0]  beat_now;
   frame_st_e         st;
   logic              take;
   logic              last;

   generate
      if (LOW_TRUE) begin : g_inv
         assign bits = ~lane_wire;
      end else begin : g_pass
         assign bits = lane_wire;
      end

      if (BEATS > 2) begin : g_shift
         assign hold_nxt = {bits, hold[HOLD_W-1:LANE_W]};
      end else begin : g_single
         assign hold_nxt = bits;
      end
   endgenerate

   assign beat_now = frame_start ? '0 : beat;
   assign take     = frame_start || (st == FR_RUN);
   assign last     = take && (beat_now == LAST_BEAT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= FR_IDLE;
         beat   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= last;
         if (last) begin
            st   <= FR_IDLE;
            beat <= '0;
         end else if (take) begin
            st   <= FR_RUN;
            beat <= beat_now + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold   <= '0;
         word_q <= '0;
      end else if (take) begin
         hold <= hold_nxt;
         if (last) begin
            word_q <= WORD_W'({bits, hold});
         end
      end
   end

endmodule

// File: rtl/reqdes_match.sv
module reqdes_match
   import reqdes_pkg::*;
#(
   parameter int PKT_W = 24,
   parameter int ID_W  = 5
) (
   input  logic [PKT_W-1:0] pkt,
   input  logic [ID_W-1:0]  dev_id,
   input  logic             done,
   output hit_t             hit
);

   logic addr_ok;

   assign addr_ok     = (pkt[ID_W-1:0] == dev_id);
   assign hit.hit_set = done && addr_ok && pkt[ID_W];
   assign hit.hit_clr = done && addr_ok && !pkt[ID_W];

endmodule

// File: rtl/reqdes_top.sv
module reqdes_top
   import reqdes_pkg::*;
#(
   parameter int ROW_W    = 3,
   parameter int COL_W    = 5,
   parameter int BEATS    = 8,
   parameter int ID_W     = 5,
   parameter int COP_W    = 23,
   parameter bit LOW_TRUE = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           frame_start,
   input  logic [ROW_W-1:0]               row_wire,
   input  logic [COL_W-1:0]               col_wire,
   input  logic [ID_W-1:0]                dev_id,
   output logic                           row_act_vld,
   output logic                           row_op_vld,
   output logic [ROW_W*BEATS-1:0]         row_pkt,
   output logic                           col_vld,
   output logic                           mask_vld,
   output logic                           xop_vld,
   output logic [COP_W-1:0]               col_pkt,
   output logic [COL_W*BEATS-COP_W-1:0]   sec_pkt
);

   localparam int ROW_PKT_W = ROW_W * BEATS;
   localparam int COL_WRD_W = COL_W * BEATS;
   localparam int SEC_W     = COL_WRD_W - COP_W;

   generate
      if (BEATS < 2) begin : g_bad_beats
         $error("reqdes_top: BEATS must be at least 2");
      end
      if (ID_W + 1 > ROW_PKT_W) begin : g_bad_row
         $error("reqdes_top: row packet too narrow for device field and flag");
      end
      if (ID_W + 1 > COP_W) begin : g_bad_cop
         $error("reqdes_top: operation packet too narrow for device field and flag");
      end
      if (SEC_W < 1) begin : g_bad_sec
         $error("reqdes_top: column word leaves no secondary packet");
      end
   endgenerate

   logic                 row_done;
   logic                 col_done;
   logic [COL_WRD_W-1:0] col_word;
   hit_t                 row_hit;
   hit_t                 col_hit;

   reqdes_lane #(.LANE_W(ROW_W), .BEATS(BEATS), .LOW_TRUE(LOW_TRUE)) u_row (
      .clk         (clk),
      .rst         (rst),
      .frame_start (frame_start),
      .lane_wire   (row_wire),
      .word_q      (row_pkt),
      .done_q      (row_done)
   );

   reqdes_lane #(.LANE_W(COL_W), .BEATS(BEATS), .LOW_TRUE(LOW_TRUE)) u_col (
      .clk         (clk),
      .rst         (rst),
      .frame_start (frame_start),
      .lane_wire   (col_wire),
      .word_q      (col_word),
      .done_q      (col_done)
   );

   assign col_pkt = col_word[COP_W-1:0];
   assign sec_pkt = col_word[COL_WRD_W-1:COP_W];

   reqdes_match #(.PKT_W(ROW_PKT_W), .ID_W(ID_W)) u_row_match (
      .pkt    (row_pkt),
      .dev_id (dev_id),
      .done   (row_done),
      .hit    (row_hit)
   );

   reqdes_match #(.PKT_W(COP_W), .ID_W(ID_W)) u_col_match (
      .pkt    (col_pkt),
      .dev_id (dev_id),
      .done   (col_done),
      .hit    (col_hit)
   );

   assign row_act_vld = row_hit.hit_set;
   assign row_op_vld  = row_hit.hit_clr;
   assign mask_vld    = col_hit.hit_set;
   assign xop_vld     = col_hit.hit_clr;
   assign col_vld     = col_hit.hit_set | col_hit.hit_clr;

endmodule

// File: rtl/reqdes_chk.sv
module reqdes_chk #(
   parameter int ID_W = 5
) (
   input logic            clk,
   input logic            rst,
   input logic            row_done,
   input logic            col_done,
   input logic            row_act_vld,
   input logic            row_op_vld,
   input logic            col_vld,
   input logic            mask_vld,
   input logic            xop_vld,
   input logic [ID_W-1:0] row_id,
   input logic [ID_W-1:0] col_id,
   input logic [ID_W-1:0] dev_id
);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) row_done |=> !row_done); // R1
   AST_LANES_LOCKSTEP: assert property (@(posedge clk) disable iff (rst) row_done == col_done); // R10
   AST_ROW_ADDR_HIT: assert property (@(posedge clk) disable iff (rst) (row_act_vld || row_op_vld) |-> (row_id == dev_id)); // R4
   AST_COL_ADDR_HIT: assert property (@(posedge clk) disable iff (rst) col_vld |-> (col_id == dev_id)); // R5
   AST_COL_HAS_KIND: assert property (@(posedge clk) disable iff (rst) col_vld |-> (mask_vld || xop_vld)); // R5
   AST_SEC_ONE_KIND: assert property (@(posedge clk) disable iff (rst) $onehot0({mask_vld, xop_vld})); // R6
   AST_ROW_ONE_KIND: assert property (@(posedge clk) disable iff (rst) $onehot0({row_act_vld, row_op_vld})); // R7

endmodule

bind reqdes_top reqdes_chk #(.ID_W(ID_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .row_done    (row_done),
   .col_done    (col_done),
   .row_act_vld (row_act_vld),
   .row_op_vld  (row_op_vld),
   .col_vld     (col_vld),
   .mask_vld    (mask_vld),
   .xop_vld     (xop_vld),
   .row_id      (row_pkt[ID_W-1:0]),
   .col_id      (col_pkt[ID_W-1:0]),
   .dev_id      (dev_id)
);

// File: tb/reqdes_top_tb.sv
`timescale 1ns/1ps
module reqdes_top_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        frame_start = 1'b0;
   logic [2:0]  row_wire = '1;
   logic [4:0]  col_wire = '1;
   logic [4:0]  dev_id = '0;
   logic        row_act_vld, row_op_vld, col_vld, mask_vld, xop_vld;
   logic [23:0] row_pkt;
   logic [22:0] col_pkt;
   logic [16:0] sec_pkt;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   reqdes_top u_dut (
      .clk(clk), .rst(rst), .frame_start(frame_start),
      .row_wire(row_wire), .col_wire(col_wire), .dev_id(dev_id),
      .row_act_vld(row_act_vld), .row_op_vld(row_op_vld), .row_pkt(row_pkt),
      .col_vld(col_vld), .mask_vld(mask_vld), .xop_vld(xop_vld),
      .col_pkt(col_pkt), .sec_pkt(sec_pkt)
   );

   // {row word, column word, device id}
   localparam logic [68:0] VEC [0:7] = '{
      {24'hA53C21, 40'h1234567861, 5'd1},
      {24'h000001, 40'h0000000001, 5'd1},
      {24'hFFFFE3, 40'hFFFFFFFFC3, 5'd3},
      {24'h123427, 40'h0000000025, 5'd5},
      {24'h000000, 40'hAAAAAAAAAA, 5'd0},
      {24'h5A5A3F, 40'h555555553F, 5'd31},
      {24'h800010, 40'h8000000030, 5'd16},
      {24'h00001E, 40'h000000001F, 5'd30}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      frame_start = 1'b0;
      row_wire    = '1;
      col_wire    = '1;
   endtask

   task automatic put_beat(input logic fs, input logic [23:0] rw, input logic [39:0] cw, input int t);
      frame_start = fs;
      row_wire    = ~rw[3*t +: 3];
      col_wire    = ~cw[5*t +: 5];
   endtask

   task automatic drive_frame(input logic [23:0] rw, input logic [39:0] cw);
      for (int t = 0; t < 8; t++) begin
         @(negedge clk);
         put_beat(t == 0, rw, cw, t);
      end
   endtask

   function automatic logic [63:0] strobes();
      return {59'd0, row_act_vld, row_op_vld, col_vld, mask_vld, xop_vld};
   endfunction

   task automatic check_out(input logic [23:0] rw, input logic [39:0] cw, input logic [4:0] id);
      logic rh, ch;
      logic [63:0] exp_s;
      rh = (rw[4:0] == id);
      ch = (cw[4:0] == id);
      exp_s = {59'd0, rh & rw[5], rh & ~rw[5], ch, ch & cw[5], ch & ~cw[5]};
      chk(row_pkt == rw, "R1/R3 row packet", 64'(row_pkt), 64'(rw));
      chk({sec_pkt, col_pkt} == cw, "R2/R3 column word", 64'({sec_pkt, col_pkt}), 64'(cw));
      chk(strobes() == exp_s, "R4/R5/R6/R7 strobes", strobes(), exp_s);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      summary();
      $finish;
   end

   initial begin
      logic quiet;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(strobes() == 0, "R9 strobes in reset", strobes(), 64'd0);
      rst = 1'b0;

      // R9: lane activity without a frame-start
      quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         row_wire = 3'(i); col_wire = 5'(i * 7);
         if (strobes() != 0) quiet = 1'b0;
      end
      idle();
      chk(quiet, "R9 no strobe without frame-start", 64'(!quiet), 64'd0);

      // R1..R7: vector table
      for (int v = 0; v < 8; v++) begin
         dev_id = VEC[v][4:0];
         drive_frame(VEC[v][68:45], VEC[v][44:5]);
         chk(strobes() == 0, "R1 no strobe before bit-time 7 edge", strobes(), 64'd0);
         @(negedge clk);
         idle();
         check_out(VEC[v][68:45], VEC[v][44:5], VEC[v][4:0]);
         @(negedge clk);
         chk(strobes() == 0, "R1 strobe lasts one cycle", strobes(), 64'd0);
      end

      // R8: restart in mid-frame
      dev_id = 5'd1;
      for (int t = 0; t < 3; t++) begin
         @(negedge clk);
         put_beat(t == 0, 24'hFFFFE1, 40'hFFFFFFFFE1, t);
      end
      drive_frame(24'h000001, 40'h0000000021);
      chk(strobes() == 0, "R8 dropped partial frame gives no strobe", strobes(), 64'd0);
      @(negedge clk);
      idle();
      check_out(24'h000001, 40'h0000000021, 5'd1);

      // R9: reset cuts a frame short
      for (int t = 0; t < 4; t++) begin
         @(negedge clk);
         put_beat(t == 0, 24'h000021, 40'h0000000021, t);
      end
      @(negedge clk);
      idle();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      quiet = 1'b1;
      for (int t = 4; t < 12; t++) begin
         @(negedge clk);
         if (t < 8) put_beat(1'b0, 24'h000021, 40'h0000000021, t);
         else idle();
         if (strobes() != 0) quiet = 1'b0;
      end
      chk(quiet, "R9 frame cut by reset never completes", 64'(!quiet), 64'd0);

      // R10: back-to-back frames
      dev_id = 5'd3;
      drive_frame(24'hABC023, 40'h1122334423);
      @(negedge clk);
      check_out(24'hABC023, 40'h1122334423, 5'd3);
      put_beat(1'b1, 24'h000003, 40'h0000000003, 0);
      for (int t = 1; t < 8; t++) begin
         @(negedge clk);
         if (t == 1) chk(strobes() == 0, "R10 gap inside second frame", strobes(), 64'd0);
         put_beat(1'b0, 24'h000003, 40'h0000000003, t);
      end
      @(negedge clk);
      idle();
      check_out(24'h000003, 40'h0000000003, 5'd3);

      summary();
      $finish;
   end

endmodule